// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block carries out the hardware side of taking an interrupt and coming back from one in a small 8-bit processor core. When a software break is requested, or a hardware request arrives while interrupts are enabled, it saves the program counter and the status byte on a stack that grows downward in a fixed page. It then sets the interrupt-disable flag and fetches the new program counter from a two-byte vector. A return command runs the steps in reverse: it pulls the status byte and the program counter back off the stack.

The core supplies its current program counter, status and stack pointer, together with the vector address of the selected source. The sequencer makes exactly one byte-wide memory access per busy cycle. When it finishes, it pulses `done`, and the core copies the updated values from `pc_o`, `ps_o` and `sp_o`. Decoding instructions and arbitrating between interrupt sources are handled elsewhere.

Top module: `irq_seq_top`

## Requirements
- R1: After reset, `busy`, `done`, `mem_we` and `mem_re` are all 0.
- R2: An entry writes the program counter high byte to address {page,S}, then the low byte to {page,S-1}. The page is 0x01.
- R3: After an entry, `sp_o` equals the starting stack pointer minus 3.
- R4: The third write of an entry goes to {page,S-2} and stores the status input with bit 4 forced: 1 for a break, 0 for a hardware request. All other bits are stored unchanged.
- R5: After an entry, `ps_o` equals the status input with bit 2 (interrupt disable) set and every other bit unchanged.
- R6: After the three pushes, the block reads the vector address and then the vector address plus 1. `pc_o` becomes {second byte, first byte}.
- R7: A hardware request is ignored while status bit 2 of `ps_in` is 1: no bus access occurs and `busy` stays 0. A break is taken whatever the value of that bit.
- R8: A return reads {page,S+1}, {page,S+2} and {page,S+3}, in that order, into the status, PC low byte and PC high byte. The stack pointer ends at S+3.
- R9: `busy` is high for exactly 5 cycles on an entry and 3 cycles on a return, with one access (write or read) in every busy cycle. `done` is a one-cycle pulse in the cycle after the last access.
- R10: Requests are sampled only while idle, including the `done` cycle. Break wins over a hardware request, and a hardware request wins over return. Requests raised while busy have no effect.
- R11: The stack pointer wraps modulo 256, both when pushing and when popping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| brk_req | input | 1 | Software break request |
| irq_req | input | 1 | Hardware interrupt request |
| rti_req | input | 1 | Return-from-interrupt command |
| vec_addr | input | 16 | Vector address of the selected source |
| pc_in | input | 16 | Current program counter |
| ps_in | input | 8 | Current processor status |
| sp_in | input | 8 | Current stack pointer |
| mem_rdata | input | 8 | Read data, valid in the same cycle as the address |
| mem_addr | output | 16 | Memory address |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| mem_wdata | output | 8 | Write data |
| pc_o | output | 16 | Updated program counter, valid with `done` |
| ps_o | output | 8 | Updated status, valid with `done` |
| sp_o | output | 8 | Updated stack pointer, valid with `done` |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with its default parameters: an 8-bit data path, stack page 0x01, interrupt disable at bit 2 and the break mark at bit 4. With these values, stack pointers of 0x00 to 0x02 and 0xFD to 0xFF make pushes and pops cross the 0x00/0xFF boundary, so the modulo-256 wrap can be reached. Mixed status patterns show that only bits 2 and 4 are altered. Requests that coincide, and requests held through a busy sequence, exercise the priority order and the idle-only sampling.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  // Sequencer phases: pushes, vector fetch, pops
  typedef enum logic [3:0] {
    ST_IDLE  = 4'd0,
    ST_PSH_H = 4'd1,
    ST_PSH_L = 4'd2,
    ST_PSH_P = 4'd3,
    ST_VEC_L = 4'd4,
    ST_VEC_H = 4'd5,
    ST_POP_P = 4'd6,
    ST_POP_L = 4'd7,
    ST_POP_H = 4'd8
  } seq_state_e;

  // Which command the idle sequencer takes this cycle
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_BRK  = 2'd1,
    SRC_IRQ  = 2'd2,
    SRC_RTI  = 2'd3
  } src_e;

endpackage

// File: rtl/irq_seq_rstsync.sv
module irq_seq_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign rst_n_sync = sh_q[STAGES-1];

endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
  import irq_seq_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int IDIS_BIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              brk_req,
  input  logic              irq_req,
  input  logic              rti_req,
  input  logic [DATA_W-1:0] ps_in,
  output seq_state_e        state,
  output src_e              start,
  output logic              done
);

  seq_state_e state_q, state_d;
  logic       done_q, done_d;

  // Arbitration: break over hardware request over return
  always_comb begin
    start = SRC_NONE;
    if (state_q == ST_IDLE) begin
      if (brk_req) begin
        start = SRC_BRK;
      end else if (irq_req && !ps_in[IDIS_BIT]) begin
        start = SRC_IRQ;
      end else if (rti_req) begin
        start = SRC_RTI;
      end
    end
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start == SRC_BRK || start == SRC_IRQ) begin
          state_d = ST_PSH_H;
        end else if (start == SRC_RTI) begin
          state_d = ST_POP_P;
        end
      end
      ST_PSH_H: state_d = ST_PSH_L;
      ST_PSH_L: state_d = ST_PSH_P;
      ST_PSH_P: state_d = ST_VEC_L;
      ST_VEC_L: state_d = ST_VEC_H;
      ST_VEC_H: state_d = ST_IDLE;
      ST_POP_P: state_d = ST_POP_L;
      ST_POP_L: state_d = ST_POP_H;
      ST_POP_H: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
    done_d = (state_q == ST_VEC_H) || (state_q == ST_POP_H);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  assign state = state_q;
  assign done  = done_q;

endmodule

// File: rtl/irq_seq_regs.sv
module irq_seq_regs
  import irq_seq_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int IDIS_BIT = 2,
  localparam int ADDR_W  = 2 * DATA_W,
  localparam int LANES   = ADDR_W / DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_state_e        state,
  input  src_e              start,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [DATA_W-1:0] ps_in,
  input  logic [DATA_W-1:0] sp_in,
  input  logic [ADDR_W-1:0] vec_in,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] pc_q,
  output logic [DATA_W-1:0] ps_q,
  output logic [DATA_W-1:0] sp_q,
  output logic              brk_q,
  output logic [ADDR_W-1:0] vec_q
);

  logic cap_en, sp_dec_en, sp_inc_en, ps_rd_en, idis_set_en;
  logic [LANES-1:0] lane_en;

  logic [DATA_W-1:0] sp_d, ps_d;
  logic              brk_d;
  logic [ADDR_W-1:0] vec_d;
  logic              sp_en, ps_en;

  // Clock enables
  always_comb begin
    cap_en      = (start != SRC_NONE);
    sp_dec_en   = (state == ST_PSH_H) || (state == ST_PSH_L) || (state == ST_PSH_P);
    sp_inc_en   = (state == ST_POP_P) || (state == ST_POP_L) || (state == ST_POP_H);
    ps_rd_en    = (state == ST_POP_P);
    idis_set_en = (state == ST_PSH_P);
    lane_en[0]  = (state == ST_VEC_L) || (state == ST_POP_L);
    lane_en[1]  = (state == ST_VEC_H) || (state == ST_POP_H);
    sp_en       = cap_en || sp_dec_en || sp_inc_en;
    ps_en       = cap_en || ps_rd_en || idis_set_en;
  end

  // Next values
  always_comb begin
    sp_d = sp_q;
    if (cap_en) begin
      sp_d = sp_in;
    end else if (sp_dec_en) begin
      sp_d = sp_q - DATA_W'(1);
    end else if (sp_inc_en) begin
      sp_d = sp_q + DATA_W'(1);
    end

    ps_d = ps_q;
    if (cap_en) begin
      ps_d = ps_in;
    end else if (ps_rd_en) begin
      ps_d = rd_data;
    end else if (idis_set_en) begin
      ps_d[IDIS_BIT] = 1'b1;
    end

    brk_d = (start == SRC_BRK);
    vec_d = vec_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q <= '0;
    end else if (sp_en) begin
      sp_q <= sp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_q <= '0;
    end else if (ps_en) begin
      ps_q <= ps_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_q <= 1'b0;
      vec_q <= '0;
    end else if (cap_en) begin
      brk_q <= brk_d;
      vec_q <= vec_d;
    end
  end

  // One byte lane of the program counter per generate pass
  for (genvar b = 0; b < LANES; b++) begin : g_pc_lane
    logic [DATA_W-1:0] lane_d;
    logic              lane_load;

    always_comb begin
      lane_load = cap_en || lane_en[b];
      lane_d    = cap_en ? pc_in[b*DATA_W +: DATA_W] : rd_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pc_q[b*DATA_W +: DATA_W] <= '0;
      end else if (lane_load) begin
        pc_q[b*DATA_W +: DATA_W] <= lane_d;
      end
    end
  end

endmodule

// File: rtl/irq_seq_busmux.sv
module irq_seq_busmux
  import irq_seq_pkg::*;
#(
  parameter int                DATA_W     = 8,
  parameter logic [DATA_W-1:0] STACK_PAGE = 8'h01,
  parameter int                BRK_BIT    = 4,
  localparam int               ADDR_W     = 2 * DATA_W
) (
  input  seq_state_e        state,
  input  logic [ADDR_W-1:0] pc_q,
  input  logic [DATA_W-1:0] ps_q,
  input  logic [DATA_W-1:0] sp_q,
  input  logic              brk_q,
  input  logic [ADDR_W-1:0] vec_q,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic              mem_re,
  output logic [DATA_W-1:0] mem_wdata
);

  logic [DATA_W-1:0] sp_pre_inc;
  logic [DATA_W-1:0] ps_marked;

  always_comb begin
    sp_pre_inc         = sp_q + DATA_W'(1);
    ps_marked          = ps_q;
    ps_marked[BRK_BIT] = brk_q;

    mem_addr  = '0;
    mem_we    = 1'b0;
    mem_re    = 1'b0;
    mem_wdata = '0;
    unique case (state)
      ST_PSH_H: begin
        mem_addr  = {STACK_PAGE, sp_q};
        mem_we    = 1'b1;
        mem_wdata = pc_q[ADDR_W-1 -: DATA_W];
      end
      ST_PSH_L: begin
        mem_addr  = {STACK_PAGE, sp_q};
        mem_we    = 1'b1;
        mem_wdata = pc_q[DATA_W-1:0];
      end
      ST_PSH_P: begin
        mem_addr  = {STACK_PAGE, sp_q};
        mem_we    = 1'b1;
        mem_wdata = ps_marked;
      end
      ST_VEC_L: begin
        mem_addr = vec_q;
        mem_re   = 1'b1;
      end
      ST_VEC_H: begin
        mem_addr = vec_q + ADDR_W'(1);
        mem_re   = 1'b1;
      end
      ST_POP_P, ST_POP_L, ST_POP_H: begin
        mem_addr = {STACK_PAGE, sp_pre_inc};
        mem_re   = 1'b1;
      end
      default: begin
        mem_addr = '0;
      end
    endcase
  end

endmodule

// File: rtl/irq_seq_top.sv
module irq_seq_top
  import irq_seq_pkg::*;
#(
  parameter int                DATA_W      = 8,
  parameter logic [DATA_W-1:0] STACK_PAGE  = 8'h01,
  parameter int                IDIS_BIT    = 2,
  parameter int                BRK_BIT     = 4,
  parameter int                SYNC_STAGES = 2,
  localparam int               ADDR_W      = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              brk_req,
  input  logic              irq_req,
  input  logic              rti_req,
  input  logic [ADDR_W-1:0] vec_addr,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [DATA_W-1:0] ps_in,
  input  logic [DATA_W-1:0] sp_in,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic              mem_re,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] ps_o,
  output logic [DATA_W-1:0] sp_o,
  output logic              busy,
  output logic              done
);

  logic              rst_ni;
  seq_state_e        st;
  src_e              start;
  logic [ADDR_W-1:0] pc_q;
  logic [DATA_W-1:0] ps_q;
  logic [DATA_W-1:0] sp_q;
  logic              brk_q;
  logic [ADDR_W-1:0] vec_q;

  irq_seq_rstsync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_ni)
  );

  irq_seq_fsm #(.DATA_W(DATA_W), .IDIS_BIT(IDIS_BIT)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_ni),
    .brk_req (brk_req),
    .irq_req (irq_req),
    .rti_req (rti_req),
    .ps_in   (ps_in),
    .state   (st),
    .start   (start),
    .done    (done)
  );

  irq_seq_regs #(.DATA_W(DATA_W), .IDIS_BIT(IDIS_BIT)) u_regs (
    .clk     (clk),
    .rst_n   (rst_ni),
    .state   (st),
    .start   (start),
    .pc_in   (pc_in),
    .ps_in   (ps_in),
    .sp_in   (sp_in),
    .vec_in  (vec_addr),
    .rd_data (mem_rdata),
    .pc_q    (pc_q),
    .ps_q    (ps_q),
    .sp_q    (sp_q),
    .brk_q   (brk_q),
    .vec_q   (vec_q)
  );

  irq_seq_busmux #(.DATA_W(DATA_W), .STACK_PAGE(STACK_PAGE), .BRK_BIT(BRK_BIT)) u_bus (
    .state     (st),
    .pc_q      (pc_q),
    .ps_q      (ps_q),
    .sp_q      (sp_q),
    .brk_q     (brk_q),
    .vec_q     (vec_q),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .mem_wdata (mem_wdata)
  );

  assign busy = (st != ST_IDLE);
  assign pc_o = pc_q;
  assign ps_o = ps_q;
  assign sp_o = sp_q;

endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk
  import irq_seq_pkg::*;
#(
  parameter int                DATA_W     = 8,
  parameter logic [DATA_W-1:0] STACK_PAGE = 8'h01,
  parameter int                IDIS_BIT   = 2,
  localparam int               ADDR_W     = 2 * DATA_W
) (
  input logic              clk,
  input logic              rst_ni,
  input seq_state_e        st,
  input logic              busy,
  input logic              done,
  input logic              mem_we,
  input logic              mem_re,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] sp_o,
  input logic [DATA_W-1:0] ps_o,
  input logic              brk_req,
  input logic              irq_req,
  input logic              rti_req,
  input logic [DATA_W-1:0] ps_in
);

  // R2
  push_addr_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    mem_we |-> (mem_addr == {STACK_PAGE, sp_o}));

  // R3
  push_dec_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    mem_we |=> (sp_o == $past(sp_o) - DATA_W'(1)));

  // R5
  idis_set_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (st == ST_PSH_P) |=> ps_o[IDIS_BIT]);

  // R7
  masked_irq_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (!busy && irq_req && !brk_req && !rti_req && ps_in[IDIS_BIT]) |=> !busy);

  // R8
  pop_addr_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (st == ST_POP_P || st == ST_POP_L || st == ST_POP_H)
      |-> (mem_re && mem_addr == {STACK_PAGE, sp_o + DATA_W'(1)}));

  // R9
  one_access_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    busy |-> $onehot({mem_we, mem_re}));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !busy |-> !(mem_we || mem_re));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    done |=> !done);

  // R9
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    done |-> (!busy && $past(busy)));

endmodule

bind irq_seq_top irq_seq_chk #(
  .DATA_W     (DATA_W),
  .STACK_PAGE (STACK_PAGE),
  .IDIS_BIT   (IDIS_BIT)
) u_chk (
  .clk      (clk),
  .rst_ni   (rst_ni),
  .st       (st),
  .busy     (busy),
  .done     (done),
  .mem_we   (mem_we),
  .mem_re   (mem_re),
  .mem_addr (mem_addr),
  .sp_o     (sp_o),
  .ps_o     (ps_o),
  .brk_req  (brk_req),
  .irq_req  (irq_req),
  .rti_req  (rti_req),
  .ps_in    (ps_in)
);

// File: tb/tb_irq_seq_top.sv
`timescale 1ns/1ps
module tb_irq_seq_top;

  typedef struct {
    bit          we;
    logic [15:0] addr;
    logic [7:0]  data;
    string       tag;
  } op_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        brk_req, irq_req, rti_req;
  logic [15:0] vec_addr, pc_in;
  logic [7:0]  ps_in, sp_in;
  logic [7:0]  mem_rdata;
  logic [15:0] mem_addr;
  logic        mem_we, mem_re;
  logic [7:0]  mem_wdata;
  logic [15:0] pc_o;
  logic [7:0]  ps_o, sp_o;
  logic        busy, done;

  logic [7:0] stk [256];

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  finished = 0;

  op_t         q[$];
  bit          exp_done;
  logic [15:0] fin_pc;
  logic [7:0]  fin_ps, fin_sp;
  string       pc_tag, ps_tag, sp_tag;
  string       idle_tag = "R9";

  always #2 clk = ~clk;

  function automatic logic [7:0] vbyte(logic [15:0] a);
    return (a[7:0] * 8'd3) ^ a[15:8] ^ 8'hA5;
  endfunction

  assign mem_rdata = (mem_addr[15:8] == 8'h01) ? stk[mem_addr[7:0]] : vbyte(mem_addr);

  always @(posedge clk) begin
    if (mem_we) stk[mem_addr[7:0]] <= mem_wdata;
  end

  irq_seq_top dut (
    .clk(clk), .rst_n(rst_n), .brk_req(brk_req), .irq_req(irq_req), .rti_req(rti_req),
    .vec_addr(vec_addr), .pc_in(pc_in), .ps_in(ps_in), .sp_in(sp_in),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
    .mem_wdata(mem_wdata), .pc_o(pc_o), .ps_o(ps_o), .sp_o(sp_o),
    .busy(busy), .done(done)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Behavioural model: on acceptance, queue the bus operations to expect
  task automatic accept();
    logic [7:0] s;
    s = sp_in;
    if (brk_req || (irq_req && !ps_in[2])) begin
      logic [7:0] pushed;
      pushed = brk_req ? (ps_in | 8'h10) : (ps_in & 8'hEF);
      q.push_back('{1'b1, {8'h01, s},          pc_in[15:8], "R2"});
      q.push_back('{1'b1, {8'h01, s - 8'd1},   pc_in[7:0],  "R2"});
      q.push_back('{1'b1, {8'h01, s - 8'd2},   pushed,      "R4"});
      q.push_back('{1'b0, vec_addr,            8'h00,       "R6"});
      q.push_back('{1'b0, vec_addr + 16'd1,    8'h00,       "R6"});
      fin_pc = {vbyte(vec_addr + 16'd1), vbyte(vec_addr)};
      fin_ps = ps_in | 8'h04;
      fin_sp = s - 8'd3;
      pc_tag = "R6"; ps_tag = "R5";
      sp_tag = (s < 8'd3) ? "R11" : "R3";
    end else if (rti_req) begin
      q.push_back('{1'b0, {8'h01, s + 8'd1}, 8'h00, "R8"});
      q.push_back('{1'b0, {8'h01, s + 8'd2}, 8'h00, "R8"});
      q.push_back('{1'b0, {8'h01, s + 8'd3}, 8'h00, "R8"});
      fin_ps = stk[s + 8'd1];
      fin_pc = {stk[s + 8'd3], stk[s + 8'd2]};
      fin_sp = s + 8'd3;
      pc_tag = "R8"; ps_tag = "R8";
      sp_tag = (s > 8'd252) ? "R11" : "R8";
    end
  endtask

  task automatic compare();
    chk("R9", "busy", busy, (q.size() != 0));
    chk("R9", "done", done, exp_done);
    if (q.size() != 0) begin
      chk(q[0].tag, "we", mem_we, q[0].we);
      chk(q[0].tag, "re", mem_re, !q[0].we);
      chk(q[0].tag, "addr", mem_addr, q[0].addr);
      if (q[0].we) chk(q[0].tag, "wdata", mem_wdata, q[0].data);
    end else begin
      chk(idle_tag, "idle we", mem_we, 1'b0);
      chk(idle_tag, "idle re", mem_re, 1'b0);
    end
    if (exp_done) begin
      chk(pc_tag, "pc_o", pc_o, fin_pc);
      chk(ps_tag, "ps_o", ps_o, fin_ps);
      chk(sp_tag, "sp_o", sp_o, fin_sp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    if (q.size() != 0) begin
      void'(q.pop_front());
      exp_done = (q.size() == 0);
    end else begin
      exp_done = 1'b0;
      accept();
    end
    @(negedge clk);
    compare();
  endtask

  task automatic run(bit b, bit i, bit r, logic [15:0] pc, logic [7:0] ps,
                     logic [7:0] sp, logic [15:0] vec, int n);
    pc_in = pc; ps_in = ps; sp_in = sp; vec_addr = vec;
    brk_req = b; irq_req = i; rti_req = r;
    tick();
    brk_req = 0; irq_req = 0; rti_req = 0;
    repeat (n) tick();
  endtask

  initial begin
    #400000;
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 256; k++) stk[k] = 8'(k ^ 8'h3C);
    rst_n = 0; brk_req = 0; irq_req = 0; rti_req = 0;
    pc_in = 0; ps_in = 0; sp_in = 8'hFF; vec_addr = 16'hFFFE;
    exp_done = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "busy", busy, 0);
    chk("R1", "done", done, 0);
    chk("R1", "we", mem_we, 0);
    chk("R1", "re", mem_re, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R2 R4 R5 R6: hardware entry, interrupts enabled
    run(0, 1, 0, 16'h1234, 8'h00, 8'hFF, 16'hFFFA, 7);
    // R8: return restores the pushed state
    run(0, 0, 1, 16'h0000, 8'h04, 8'hFC, 16'h0000, 5);
    // R7: masked hardware request is ignored
    idle_tag = "R7";
    run(0, 1, 0, 16'hBEEF, 8'hC4, 8'h80, 16'hFFFA, 4);
    idle_tag = "R9";
    // R7 R4 R11: break taken while masked, stack wraps below 0
    run(1, 0, 0, 16'hA55A, 8'hE5, 8'h01, 16'hFFFE, 7);
    // R8 R11: return wraps above FF
    run(0, 0, 1, 16'h0000, 8'h00, 8'hFE, 16'h0000, 5);
    // R10: all three together, break wins
    run(1, 1, 1, 16'h0F0F, 8'h5A, 8'h40, 16'h2000, 7);
    // R10: hardware request beats return
    run(0, 1, 1, 16'h7001, 8'h81, 8'h90, 16'h3001, 7);
    // R10: requests held through a busy entry are ignored
    pc_in = 16'h4242; ps_in = 8'h10; sp_in = 8'h02; vec_addr = 16'hFFFF;
    irq_req = 1; rti_req = 1;
    tick();
    ps_in = 8'h00;
    repeat (5) tick();
    irq_req = 0; rti_req = 0;
    repeat (3) tick();
    // Varied patterns
    for (int k = 0; k < 12; k++) begin
      run(k[0], 1, 0, 16'(k * 16'h1357), 8'(k * 8'h1B) & 8'hFB, 8'(k * 8'h2F),
          16'(16'hFF00 + k * 2), 6);
      run(0, 0, 1, 16'h0000, 8'h00, 8'(k * 8'h2F) - 8'd3, 16'h0000, 4);
    end
    repeat (4) tick();

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule